// File: doc/BRIEF.md
# Sub-word I/O Access Adapter

This block sits between a 128-byte, byte-addressed I/O window and register banks that only accept aligned 32-bit words. A host access carries an address, a size of one, two or four bytes and, for writes, data in the low-order bytes. The adapter decodes the word address into one of three targets and presents a word index together with a write or read strobe. The targets are a 16-word core bank, an 8-word DMA bank and one bus-control register. Offsets outside these targets are holes: reads return zero and writes are discarded.

Narrow or unaligned writes never reach a bank as partial words. In the request cycle the adapter takes the target's current word from a side-effect-free port and overlays the host bytes at their little-endian lanes. It then issues the result as a single full-word write in the same cycle, so no other access can land between the fetch and the write-back. Reads fetch the whole word and return it shifted down by the byte offset and masked to the access size, one cycle after the request.

Top module: `sw_io_adapter`

## Requirements
- R1: A word address (offset with bits 1:0 cleared) from 0x00 to 0x3C selects the core bank, with index equal to offset bits 5:2.
- R2: A word address from 0x40 to 0x5C selects the DMA bank, with index equal to (offset minus 0x40) shifted right by 2.
- R3: Offsets 0x70 to 0x73 select the bus-control register.
- R4: Any other offset is a hole: a read returns 0 and a write raises no write strobe and changes no register.
- R5: size_i encodes 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. A write places host byte k (wdata_i bits 8k+7:8k) at byte lane (offset mod 4)+k of the target word. Lanes it does not cover keep the target's current value, and host bytes that would fall past lane 3 are dropped.
- R6: An aligned four-byte write delivers wdata_i unchanged as the written word.
- R7: For a read, rdata_o in the cycle after the request equals the target word shifted right by 8 times (offset mod 4) and masked to the access size; rvalid_o is high in exactly that cycle.
- R8: A read strobe is raised only for a host read and only for the decoded target; a write never raises a read strobe, even when it merges.
- R9: At most one write strobe is high, only in a cycle with req_i and we_i high, and the fetch and write-back of one access complete within its request cycle.
- R10: After reset, rvalid_o and rdata_o are 0 and no strobe is high while req_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte offset in the window |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data, low-order bytes first |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data, right-aligned |
| core_idx_o | output | 4 | Core bank word index |
| core_cur_i | input | 32 | Current core word at core_idx_o |
| core_re_o | output | 1 | Core bank read strobe |
| core_we_o | output | 1 | Core bank write strobe |
| dma_idx_o | output | 3 | DMA bank word index |
| dma_cur_i | input | 32 | Current DMA word at dma_idx_o |
| dma_re_o | output | 1 | DMA bank read strobe |
| dma_we_o | output | 1 | DMA bank write strobe |
| bctl_cur_i | input | 32 | Current bus-control word |
| bctl_re_o | output | 1 | Bus-control read strobe |
| bctl_we_o | output | 1 | Bus-control write strobe |
| reg_wdata_o | output | 32 | Full word to write |

## Verification
Assertions check on every cycle that no more than one write strobe and one read strobe are active, and that nothing fires without a request. They also check that writes never raise a read strobe, that holes stay silent, that aligned word writes pass through untouched, and that rvalid_o follows each read by one cycle. Only the bench scenarios can show that merged bytes land in the right lanes and that overhanging bytes are dropped. They also show that the right word of the right bank changes and that read data is shifted and masked correctly. The bench checks these against its own model of the three banks under random and directed accesses.

// File: rtl/sw_io_pkg.sv
`timescale 1ns/1ps
package sw_io_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_HOLE = 2'd0,
    RG_CORE = 2'd1,
    RG_DMA  = 2'd2,
    RG_BCTL = 2'd3
  } region_e;

  function automatic int size_bytes(acc_size_e sz, int word_bytes);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return word_bytes;
    endcase
  endfunction
endpackage

// File: rtl/sw_io_decode.sv
`timescale 1ns/1ps
module sw_io_decode
  import sw_io_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int LANE_W     = 2,
  parameter int CORE_BASE  = 'h00,
  parameter int CORE_WORDS = 16,
  parameter int DMA_BASE   = 'h40,
  parameter int DMA_WORDS  = 8,
  parameter int BCTL_ADDR  = 'h70,
  localparam int CORE_IDX_W = $clog2(CORE_WORDS),
  localparam int DMA_IDX_W  = $clog2(DMA_WORDS)
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output region_e               region_o,
  output logic [CORE_IDX_W-1:0] core_idx_o,
  output logic [DMA_IDX_W-1:0]  dma_idx_o
);
  localparam logic [ADDR_W:0]   CORE_LO  = (ADDR_W+1)'(CORE_BASE);
  localparam logic [ADDR_W:0]   CORE_END = (ADDR_W+1)'(CORE_BASE + (CORE_WORDS << LANE_W));
  localparam logic [ADDR_W:0]   DMA_LO   = (ADDR_W+1)'(DMA_BASE);
  localparam logic [ADDR_W:0]   DMA_END  = (ADDR_W+1)'(DMA_BASE + (DMA_WORDS << LANE_W));
  localparam logic [ADDR_W-1:0] BCTL_W   = ADDR_W'(BCTL_ADDR);

  logic [ADDR_W-1:0] word_addr;
  logic [ADDR_W-1:0] core_off, dma_off;
  logic              core_hit, dma_hit, bctl_hit;

  assign word_addr = {addr_i[ADDR_W-1:LANE_W], LANE_W'(0)};
  assign core_hit  = ({1'b0, word_addr} >= CORE_LO) && ({1'b0, word_addr} < CORE_END);
  assign dma_hit   = ({1'b0, word_addr} >= DMA_LO)  && ({1'b0, word_addr} < DMA_END);
  assign bctl_hit  = (word_addr == BCTL_W);

  assign core_off   = word_addr - CORE_LO[ADDR_W-1:0];
  assign dma_off    = word_addr - DMA_LO[ADDR_W-1:0];
  assign core_idx_o = core_off[CORE_IDX_W+LANE_W-1:LANE_W];
  assign dma_idx_o  = dma_off[DMA_IDX_W+LANE_W-1:LANE_W];

  always_comb begin
    if (core_hit)      region_o = RG_CORE;
    else if (dma_hit)  region_o = RG_DMA;
    else if (bctl_hit) region_o = RG_BCTL;
    else               region_o = RG_HOLE;
  end
endmodule

// File: rtl/sw_io_merge.sv
`timescale 1ns/1ps
module sw_io_merge
  import sw_io_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int WB     = DATA_W / 8,
  localparam int LANE_W = $clog2(WB)
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANE_W-1:0] lane_i,
  input  acc_size_e         size_i,
  output logic [DATA_W-1:0] word_o
);
  int n_bytes;
  assign n_bytes = size_bytes(size_i, WB);

  for (genvar b = 0; b < WB; b++) begin : g_lane
    logic [7:0] host_byte;
    logic       covered;
    always_comb begin
      host_byte = '0;
      covered   = 1'b0;
      for (int k = 0; k < WB; k++) begin
        if ((int'(lane_i) + k == b) && (k < n_bytes)) begin
          host_byte = wdata_i[8*k +: 8];
          covered   = 1'b1;
        end
      end
    end
    assign word_o[8*b +: 8] = covered ? host_byte : cur_i[8*b +: 8];
  end
endmodule

// File: rtl/sw_io_extract.sv
`timescale 1ns/1ps
module sw_io_extract
  import sw_io_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int WB     = DATA_W / 8,
  localparam int LANE_W = $clog2(WB)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  acc_size_e         size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] mask;

  assign shifted = word_i >> {lane_i, 3'b000};

  always_comb begin
    case (size_i)
      SZ_BYTE: mask = DATA_W'(8'hFF);
      SZ_HALF: mask = DATA_W'(16'hFFFF);
      default: mask = '1;
    endcase
  end

  assign data_o = shifted & mask;
endmodule

// File: rtl/sw_io_adapter.sv
`timescale 1ns/1ps
module sw_io_adapter
  import sw_io_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CORE_WORDS = 16,
  parameter int DMA_WORDS  = 8,
  parameter int DMA_BASE   = 'h40,
  parameter int BCTL_ADDR  = 'h70,
  localparam int LANE_W     = $clog2(DATA_W / 8),
  localparam int CORE_IDX_W = $clog2(CORE_WORDS),
  localparam int DMA_IDX_W  = $clog2(DMA_WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [1:0]            size_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  rvalid_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [CORE_IDX_W-1:0] core_idx_o,
  input  logic [DATA_W-1:0]     core_cur_i,
  output logic                  core_re_o,
  output logic                  core_we_o,
  output logic [DMA_IDX_W-1:0]  dma_idx_o,
  input  logic [DATA_W-1:0]     dma_cur_i,
  output logic                  dma_re_o,
  output logic                  dma_we_o,
  input  logic [DATA_W-1:0]     bctl_cur_i,
  output logic                  bctl_re_o,
  output logic                  bctl_we_o,
  output logic [DATA_W-1:0]     reg_wdata_o
);
  region_e           region;
  acc_size_e         size;
  logic [LANE_W-1:0] lane;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] rd_word;
  logic              rd_req, wr_req;

  assign size   = acc_size_e'(size_i);
  assign lane   = addr_i[LANE_W-1:0];
  assign rd_req = req_i & ~we_i;
  assign wr_req = req_i & we_i;

  sw_io_decode #(
    .ADDR_W    (ADDR_W),
    .LANE_W    (LANE_W),
    .CORE_BASE ('h00),
    .CORE_WORDS(CORE_WORDS),
    .DMA_BASE  (DMA_BASE),
    .DMA_WORDS (DMA_WORDS),
    .BCTL_ADDR (BCTL_ADDR)
  ) i_decode (
    .addr_i    (addr_i),
    .region_o  (region),
    .core_idx_o(core_idx_o),
    .dma_idx_o (dma_idx_o)
  );

  // holes merge against zero; their write is dropped anyway
  always_comb begin
    case (region)
      RG_CORE: cur_word = core_cur_i;
      RG_DMA:  cur_word = dma_cur_i;
      RG_BCTL: cur_word = bctl_cur_i;
      default: cur_word = '0;
    endcase
  end

  sw_io_merge #(.DATA_W(DATA_W)) i_merge (
    .cur_i  (cur_word),
    .wdata_i(wdata_i),
    .lane_i (lane),
    .size_i (size),
    .word_o (reg_wdata_o)
  );

  sw_io_extract #(.DATA_W(DATA_W)) i_extract (
    .word_i(cur_word),
    .lane_i(lane),
    .size_i(size),
    .data_o(rd_word)
  );

  // fetch and write-back share the request cycle: no interleaving possible
  assign core_we_o = wr_req && (region == RG_CORE);
  assign dma_we_o  = wr_req && (region == RG_DMA);
  assign bctl_we_o = wr_req && (region == RG_BCTL);
  assign core_re_o = rd_req && (region == RG_CORE);
  assign dma_re_o  = rd_req && (region == RG_DMA);
  assign bctl_re_o = rd_req && (region == RG_BCTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_word;
    end
  end

  // R9
  single_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_we_o, dma_we_o, bctl_we_o}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(core_we_o | dma_we_o | bctl_we_o | core_re_o | dma_re_o | bctl_re_o));

  // R8
  write_no_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> !(core_re_o | dma_re_o | bctl_re_o));

  // R8
  single_re_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_re_o, dma_re_o, bctl_re_o}));

  // R4
  hole_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i >= ADDR_W'('h60) && addr_i[ADDR_W-1:LANE_W] != BCTL_ADDR[ADDR_W-1:LANE_W])
      |-> !(core_we_o | dma_we_o | bctl_we_o | core_re_o | dma_re_o | bctl_re_o));

  // R6
  full_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i[1] && addr_i[LANE_W-1:0] == '0) |-> reg_wdata_o == wdata_i);

  // R7
  rvalid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R7
  rvalid_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

// File: tb/test_sw_io_adapter.sv
`timescale 1ns/1ps
module test_sw_io_adapter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        rvalid;
  logic [31:0] rdata, reg_wdata;
  logic [3:0]  core_idx;
  logic [2:0]  dma_idx;
  logic        core_re, core_we, dma_re, dma_we, bctl_re, bctl_we;

  logic [31:0] core_bank [16];
  logic [31:0] dma_bank  [8];
  logic [31:0] bctl_reg;
  logic [31:0] m_core [16];
  logic [31:0] m_dma  [8];
  logic [31:0] m_bctl;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sw_io_adapter i_sw_io_adapter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata),
    .core_idx_o(core_idx), .core_cur_i(core_bank[core_idx]), .core_re_o(core_re),
    .core_we_o(core_we), .dma_idx_o(dma_idx), .dma_cur_i(dma_bank[dma_idx]),
    .dma_re_o(dma_re), .dma_we_o(dma_we), .bctl_cur_i(bctl_reg),
    .bctl_re_o(bctl_re), .bctl_we_o(bctl_we), .reg_wdata_o(reg_wdata)
  );

  function automatic logic [31:0] init_val(int r, int i);
    return 32'hA5000000 ^ (r << 16) ^ (i * 32'h01010101) ^ 32'h00C3_3C00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) core_bank[i] <= init_val(1, i);
      for (int i = 0; i < 8; i++)  dma_bank[i]  <= init_val(2, i);
      bctl_reg <= init_val(3, 0);
    end else begin
      if (core_we) core_bank[core_idx] <= reg_wdata;
      if (dma_we)  dma_bank[dma_idx]   <= reg_wdata;
      if (bctl_we) bctl_reg            <= reg_wdata;
    end
  end

  // 0 hole, 1 core, 2 dma, 3 bctl
  function automatic int region_of(logic [6:0] a);
    logic [6:0] w = a & 7'h7C;
    if (w < 7'h40) return 1;
    if (w < 7'h60) return 2;
    if (w == 7'h70) return 3;
    return 0;
  endfunction

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_merge(logic [31:0] cur, logic [31:0] wd, int off, int n);
    logic [31:0] r = cur;
    for (int k = 0; k < n; k++)
      if (off + k < 4) r[8*(off+k) +: 8] = wd[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_extract(logic [31:0] w, int off, int n);
    logic [31:0] s = w >> (8 * off);
    return (n == 4) ? s : (s & ((32'd1 << (8 * n)) - 1));
  endfunction

  function automatic logic [31:0] model_word(logic [6:0] a);
    case (region_of(a))
      1: return m_core[a[5:2]];
      2: return m_dma[(a - 7'h40) >> 2];
      3: return m_bctl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_banks(string tag);
    bit ok = (bctl_reg == m_bctl);
    for (int i = 0; i < 16; i++) if (core_bank[i] !== m_core[i]) ok = 0;
    for (int i = 0; i < 8; i++)  if (dma_bank[i]  !== m_dma[i])  ok = 0;
    chk(ok, tag, bctl_reg, m_bctl);
  endtask

  task automatic access(bit w, logic [6:0] a, logic [1:0] s, logic [31:0] d, string tag);
    int rg = region_of(a);
    logic [5:0] exp_st, act_st;
    logic [31:0] cur = model_word(a);
    @(negedge clk);
    req = 1; we = w; addr = a; size = s; wdata = d;
    #1;
    exp_st = {w && rg == 1, w && rg == 2, w && rg == 3, !w && rg == 1, !w && rg == 2, !w && rg == 3};
    act_st = {core_we, dma_we, bctl_we, core_re, dma_re, bctl_re};
    chk(act_st == exp_st, {tag, " R8 R9 strobes"}, 32'(act_st), 32'(exp_st));
    if (w) begin
      logic [31:0] nw = exp_merge(cur, d, int'(a[1:0]), nbytes(s));
      case (rg)
        1: m_core[a[5:2]] = nw;
        2: m_dma[(a - 7'h40) >> 2] = nw;
        3: m_bctl = nw;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    req = 0;
    if (w) check_banks({tag, " R1 R2 R3 R4 R5 bank"});
    else begin
      logic [31:0] e = exp_extract(cur, int'(a[1:0]), nbytes(s));
      chk(rvalid === 1'b1, {tag, " R7 rvalid"}, 32'(rvalid), 1);
      chk(rdata === e, {tag, " R7 rdata"}, rdata, e);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) m_core[i] = init_val(1, i);
    for (int i = 0; i < 8; i++)  m_dma[i]  = init_val(2, i);
    m_bctl = init_val(3, 0);
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(rvalid === 0 && rdata === 0, "R10 reset outputs", rdata, 0);
    chk({core_we, dma_we, bctl_we, core_re, dma_re, bctl_re} === 6'b0, "R10 strobes idle", 0, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(rvalid === 0, "R10 rvalid after reset", 32'(rvalid), 0);

    // directed corners
    access(1, 7'h00, 2'd2, 32'h1122_3344, "R6 R1 aligned word core0");
    access(0, 7'h00, 2'd2, 0, "R7 word read core0");
    access(1, 7'h41, 2'd0, 32'hFFFF_FF9A, "R5 R2 byte lane1 dma0");
    access(0, 7'h41, 2'd0, 0, "R7 byte read lane1");
    access(1, 7'h5E, 2'd1, 32'h0000_BEEF, "R5 R2 half lane2 dma7");
    access(0, 7'h5E, 2'd1, 0, "R7 half read lane2");
    access(1, 7'h3F, 2'd1, 32'h0000_7788, "R5 half overhang core15");
    access(0, 7'h3C, 2'd2, 0, "R5 overhang readback");
    access(1, 7'h73, 2'd0, 32'h0000_00E1, "R3 bctl byte lane3");
    access(0, 7'h71, 2'd1, 0, "R3 R7 bctl half read");
    access(1, 7'h62, 2'd2, 32'hDEAD_BEEF, "R4 hole write 0x62");
    access(0, 7'h60, 2'd2, 0, "R4 hole read 0x60");
    access(1, 7'h7C, 2'd0, 32'h55, "R4 hole write 0x7C");
    access(0, 7'h6D, 2'd0, 0, "R4 hole read 0x6D");
    access(1, 7'h24, 2'd3, 32'hCAFE_F00D, "R5 size code 3 as word");
    access(0, 7'h26, 2'd3, 0, "R7 size3 read lane2");
    access(1, 7'h10, 2'd0, 32'h11, "R9 back-to-back byte a");
    access(1, 7'h11, 2'd0, 32'h22, "R9 back-to-back byte b");
    access(1, 7'h12, 2'd1, 32'h3344, "R9 back-to-back half c");
    access(0, 7'h10, 2'd2, 0, "R9 back-to-back readback");

    for (int it = 0; it < 600; it++) begin
      if (($urandom % 8) == 0) begin
        @(negedge clk); #1;
        chk({core_we, dma_we, bctl_we, core_re, dma_re, bctl_re} === 6'b0, "R9 idle no strobe", 0, 0);
        @(posedge clk); #1;
        chk(rvalid === 0, "R7 no read no rvalid", 32'(rvalid), 0);
      end else begin
        logic [6:0] a = 7'($urandom % 128);
        access(bit'($urandom % 2), a, 2'($urandom % 4), $urandom, "rand");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule